// File: doc/BRIEF.md
# I2C Master Byte Receive Engine

This block is the receive path of an I2C master. While it is idle, a host raises a receive request. A reloadable baud-rate counter then clocks SCL through eight full cycles and samples one SDA bit into a shift register on each rising SCL edge. After the eighth falling edge, the engine returns to idle and holds SCL low. The byte moves into a host-readable buffer, and the buffer-full and interrupt flags are raised.

The host reads the byte with a read strobe. It may then start a single-clock acknowledge sequence, which drives SDA to the chosen ACK or NACK level. Both lines are open-drain: the block drives low-enables and reads back the sampled bus levels. Because it reads SCL back, a slave that holds SCL low stretches the clock.

Three sticky flags cover the error cases:
- an overflow flag, for a byte that completes while the buffer is still unread;
- a write-collision flag, for a host write during shifting;
- an interrupt flag.

Each flag has its own clear strobe.

Top module: `i2c_rx_engine`

## Requirements
- R1: A pulse on `rx_req` starts a reception only when the engine is idle, and `rx_busy` then reads 1. A `rx_req` during a reception or during an acknowledge sequence has no effect.
- R2: Each SCL phase (released or driven low) lasts `brg_reload`+1 clock cycles. SCL changes level once at the end of each phase.
- R3: SDA is sampled when SCL is released high, most significant bit first, for eight bits.
- R4: After the eighth falling SCL edge, `rx_busy` returns to 0, the byte appears on `rx_buf`, and `buf_full` and `irq` are set. While idle, `scl_drive_low` stays 1.
- R5: A `buf_rd` strobe clears `buf_full`.
- R6: A byte that completes while `buf_full` is set sets `overflow`, and `rx_buf` keeps the older byte. `ov_clr` clears `overflow`.
- R7: A `buf_wr` during a reception sets `wcol` and leaves `rx_buf` unchanged, and `wcol_clr` clears `wcol`. A `buf_wr` while idle loads `buf_wdata` into `rx_buf` without changing `buf_full`.
- R8: A pulse on `ack_req` while idle starts an acknowledge sequence and sets `ack_busy`. During the sequence, `sda_drive_low` equals the inverse of `ack_level` (0 = ACK, line driven low). The sequence gives one SCL pulse with a high phase of `brg_reload`+1 cycles. At its end, `ack_busy` clears, `irq` sets, SDA is released and SCL is held low.
- R9: After reset, all flags are 0, `rx_buf` is 0, `rx_busy` and `ack_busy` are 0, `scl_drive_low` is 1 and `sda_drive_low` is 0.
- R10: An `irq_clr` strobe clears `irq`.
- R11: While the engine releases SCL but `scl_in` reads low, the baud counter pauses. The high phase is lengthened by the stretched cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brg_reload | input | BRG_W | Baud counter reload value (phase = value+1 cycles) |
| rx_req | input | 1 | Receive-enable request pulse |
| ack_req | input | 1 | Acknowledge-sequence request pulse |
| ack_level | input | 1 | Acknowledge level: 0 ACK, 1 NACK |
| buf_rd | input | 1 | Buffer read strobe |
| buf_wr | input | 1 | Buffer write strobe |
| buf_wdata | input | DATA_W | Buffer write data |
| ov_clr | input | 1 | Clear overflow strobe |
| wcol_clr | input | 1 | Clear write-collision strobe |
| irq_clr | input | 1 | Clear interrupt strobe |
| scl_in | input | 1 | Sampled SCL bus level |
| sda_in | input | 1 | Sampled SDA bus level |
| scl_drive_low | output | 1 | SCL low-drive enable |
| sda_drive_low | output | 1 | SDA low-drive enable |
| rx_busy | output | 1 | Receive enable, cleared by hardware at byte end |
| ack_busy | output | 1 | Acknowledge enable, cleared by hardware at sequence end |
| rx_buf | output | DATA_W | Receive buffer |
| buf_full | output | 1 | Buffer holds an unread byte |
| overflow | output | 1 | Byte lost to an unread buffer |
| wcol | output | 1 | Buffer write attempted during shifting |
| irq | output | 1 | Interrupt flag |

## Verification
The bench builds the engine with its defaults: an 8-bit byte, a 7-bit reload and MSB-first order. It programs reload values of 3 and 5, which keep each byte to a few dozen cycles, so back-to-back unread bytes, collisions in mid-byte and both acknowledge levels all fit into a short run. A slave model on the open-drain lines changes SDA only while SCL is low and can hold SCL low. This makes the phase timing, including the stretched high phase, measurable at the ports.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RX   = 2'd1,
      ST_ACK  = 2'd2
   } eng_state_t;
endpackage

// File: rtl/i2c_rx_baud.sv
module i2c_rx_baud #(
   parameter int BRG_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             en,
   input  logic [BRG_W-1:0] reload,
   output logic             tick
);
   logic [BRG_W-1:0] cnt_q;

   assign tick = en && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (load)       cnt_q <= reload;
      else if (tick)       cnt_q <= reload;
      else if (en)         cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/i2c_rx_shift.sv
module i2c_rx_shift #(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              sample_en,
   input  logic              bit_in,
   output logic [DATA_W-1:0] data
);
   logic [DATA_W-1:0] sr_q;
   logic [DATA_W-1:0] sr_next;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sr_next = {sr_q[DATA_W-2:0], bit_in};
      end else begin : g_lsb
         assign sr_next = {bit_in, sr_q[DATA_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sr_q <= '0;
      else if (clr)       sr_q <= '0;
      else if (sample_en) sr_q <= sr_next;
   end

   assign data = sr_q;
endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine
   import i2c_rx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int BRG_W     = 7,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BRG_W-1:0]  brg_reload,
   input  logic              rx_req,
   input  logic              ack_req,
   input  logic              ack_level,
   input  logic              buf_rd,
   input  logic              buf_wr,
   input  logic [DATA_W-1:0] buf_wdata,
   input  logic              ov_clr,
   input  logic              wcol_clr,
   input  logic              irq_clr,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_drive_low,
   output logic              sda_drive_low,
   output logic              rx_busy,
   output logic              ack_busy,
   output logic [DATA_W-1:0] rx_buf,
   output logic              buf_full,
   output logic              overflow,
   output logic              wcol,
   output logic              irq
);
   localparam int TOG_RX = 2 * DATA_W;
   localparam int TOG_W  = $clog2(TOG_RX + 1);

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("i2c_rx_engine: DATA_W must be at least 2");
      end
      if (BRG_W < 1) begin : g_bad_brg_w
         $error("i2c_rx_engine: BRG_W must be at least 1");
      end
   endgenerate

   eng_state_t        state_q;
   logic              scl_high_q;
   logic [TOG_W-1:0]  tog_q;
   logic [DATA_W-1:0] buf_q;
   logic              full_q, ovf_q, wcol_q, irq_q, ack_lvl_q;
   logic [DATA_W-1:0] shift_data;

   logic is_idle, start_rx, start_ack, running, stretched, tick;
   logic rise, fall, byte_done, ack_done;

   assign is_idle   = (state_q == ST_IDLE);
   assign start_rx  = is_idle && rx_req;
   assign start_ack = is_idle && ack_req && !rx_req;
   assign running   = !is_idle;
   assign stretched = scl_high_q && !scl_in;

   i2c_rx_baud #(.BRG_W(BRG_W)) u_baud (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (start_rx || start_ack),
      .en     (running && !stretched),
      .reload (brg_reload),
      .tick   (tick)
   );

   assign rise      = tick && !scl_high_q;
   assign fall      = tick && scl_high_q;
   assign byte_done = (state_q == ST_RX) && fall && (tog_q == TOG_W'(TOG_RX - 1));
   assign ack_done  = (state_q == ST_ACK) && fall;

   i2c_rx_shift #(.DATA_W(DATA_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (start_rx),
      .sample_en ((state_q == ST_RX) && rise),
      .bit_in    (sda_in),
      .data      (shift_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         scl_high_q <= 1'b0;
         tog_q      <= '0;
         ack_lvl_q  <= 1'b1;
      end else begin
         if (tick) scl_high_q <= !scl_high_q;
         case (state_q)
            ST_IDLE: begin
               tog_q <= '0;
               if (start_rx) begin
                  state_q <= ST_RX;
               end else if (start_ack) begin
                  state_q   <= ST_ACK;
                  ack_lvl_q <= ack_level;
               end
            end
            ST_RX: begin
               if (tick) tog_q <= tog_q + 1'b1;
               if (byte_done) state_q <= ST_IDLE;
            end
            ST_ACK: begin
               if (ack_done) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q  <= '0;
         full_q <= 1'b0;
         ovf_q  <= 1'b0;
         wcol_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         if (byte_done && !full_q)  buf_q <= shift_data;
         else if (buf_wr && is_idle) buf_q <= buf_wdata;

         if (byte_done)   full_q <= 1'b1;
         else if (buf_rd) full_q <= 1'b0;

         if (byte_done && full_q) ovf_q <= 1'b1;
         else if (ov_clr)         ovf_q <= 1'b0;

         if (buf_wr && (state_q == ST_RX)) wcol_q <= 1'b1;
         else if (wcol_clr)                wcol_q <= 1'b0;

         if (byte_done || ack_done) irq_q <= 1'b1;
         else if (irq_clr)          irq_q <= 1'b0;
      end
   end

   assign scl_drive_low = !scl_high_q;
   assign sda_drive_low = (state_q == ST_ACK) && !ack_lvl_q;
   assign rx_busy       = (state_q == ST_RX);
   assign ack_busy      = (state_q == ST_ACK);
   assign rx_buf        = buf_q;
   assign buf_full      = full_q;
   assign overflow      = ovf_q;
   assign wcol          = wcol_q;
   assign irq           = irq_q;
endmodule

// File: rtl/i2c_rx_engine_chk.sv
module i2c_rx_engine_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_busy,
   input logic              ack_busy,
   input logic              buf_rd,
   input logic              buf_wr,
   input logic [DATA_W-1:0] rx_buf,
   input logic              buf_full,
   input logic              overflow,
   input logic              wcol,
   input logic              irq,
   input logic              scl_drive_low,
   input logic              sda_drive_low
);
   // R1
   busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_busy && ack_busy));

   // R4
   idle_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_busy && !ack_busy) |-> scl_drive_low);

   // R4
   byte_end_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_busy) |-> (irq && buf_full));

   // R3
   rx_sda_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_busy |-> !sda_drive_low);

   // R5
   read_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_rd && !rx_busy) |=> !buf_full);

   // R6
   ovf_keeps_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> $stable(rx_buf));

   // R7
   wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_busy && buf_wr) |=> wcol);

   // R8
   ack_end_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_busy) |-> (irq && !sda_drive_low && scl_drive_low));
endmodule

bind i2c_rx_engine i2c_rx_engine_chk #(.DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rx_busy       (rx_busy),
   .ack_busy      (ack_busy),
   .buf_rd        (buf_rd),
   .buf_wr        (buf_wr),
   .rx_buf        (rx_buf),
   .buf_full      (buf_full),
   .overflow      (overflow),
   .wcol          (wcol),
   .irq           (irq),
   .scl_drive_low (scl_drive_low),
   .sda_drive_low (sda_drive_low)
);

// File: tb/i2c_rx_engine_tb.sv
module i2c_rx_engine_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int BW = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [BW-1:0] brg_reload = 7'd3;
   logic rx_req = 0, ack_req = 0, ack_level = 0, buf_rd = 0, buf_wr = 0;
   logic [DW-1:0] buf_wdata = '0;
   logic ov_clr = 0, wcol_clr = 0, irq_clr = 0;
   logic stretch = 0, sda_bit = 1;
   logic scl_in, sda_in;
   logic scl_drive_low, sda_drive_low, rx_busy, ack_busy;
   logic [DW-1:0] rx_buf;
   logic buf_full, overflow, wcol, irq;

   int checks = 0;
   int errors = 0;

   assign scl_in = !scl_drive_low && !stretch;
   assign sda_in = !sda_drive_low && sda_bit;

   always #(CLK_PERIOD/2) clk = !clk;

   i2c_rx_engine u_dut (
      .clk(clk), .rst_n(rst_n), .brg_reload(brg_reload),
      .rx_req(rx_req), .ack_req(ack_req), .ack_level(ack_level),
      .buf_rd(buf_rd), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
      .ov_clr(ov_clr), .wcol_clr(wcol_clr), .irq_clr(irq_clr),
      .scl_in(scl_in), .sda_in(sda_in),
      .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
      .rx_busy(rx_busy), .ack_busy(ack_busy), .rx_buf(rx_buf),
      .buf_full(buf_full), .overflow(overflow), .wcol(wcol), .irq(irq)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
      end
   endtask

   task automatic pulse(ref logic sig);
      sig = 1'b1;
      @(negedge clk);
      sig = 1'b0;
   endtask

   // poke: 0 none, 1 extra rx_req mid-byte, 2 buffer write mid-byte
   task automatic recv_byte(input logic [7:0] b, input int poke, input int stretch_n,
                            output int hi_cnt);
      logic [7:0] saved;
      @(negedge clk);
      pulse(rx_req);
      sda_bit = b[7];
      hi_cnt = 0;
      for (int i = 7; i >= 0; i--) begin
         if (i == 4 && poke == 1) pulse(rx_req);
         if (i == 4 && poke == 2) begin
            saved = rx_buf;
            buf_wdata = 8'hFF;
            pulse(buf_wr);
            chk(wcol, 1, "R7 wcol set by write during shifting");
            chk(rx_buf, saved, "R7 buffer unchanged by colliding write");
         end
         while (scl_drive_low) @(negedge clk);
         while (!scl_drive_low) begin
            if (i == 7) begin
               hi_cnt++;
               stretch = (stretch_n > 0) && (hi_cnt <= stretch_n);
            end
            @(negedge clk);
         end
         stretch = 0;
         sda_bit = (i > 0) ? b[i-1] : 1'b1;
      end
   endtask

   task automatic t_reset;
      chk(rx_busy, 0, "R9 rx_busy after reset");
      chk(ack_busy, 0, "R9 ack_busy after reset");
      chk({buf_full, overflow, wcol, irq}, 0, "R9 flags after reset");
      chk(rx_buf, 0, "R9 buffer after reset");
      chk(scl_drive_low, 1, "R9 SCL held low after reset");
      chk(sda_drive_low, 0, "R9 SDA released after reset");
   endtask

   task automatic t_basic;
      int hc;
      @(negedge clk);
      rx_req = 1; @(negedge clk); rx_req = 0;
      chk(rx_busy, 1, "R1 rx_busy after request");
      while (rx_busy) @(negedge clk);
      pulse(buf_rd); pulse(irq_clr);
      recv_byte(8'hA5, 0, 0, hc);
      chk(hc, 4, "R2 SCL high phase = reload+1");
      chk(rx_busy, 0, "R4 rx_busy cleared at byte end");
      chk(rx_buf, 8'hA5, "R3 received byte MSB first");
      chk(buf_full, 1, "R4 buf_full set");
      chk(irq, 1, "R4 irq set");
      chk(scl_drive_low, 1, "R4 SCL held low after byte");
      repeat (6) @(negedge clk);
      chk(scl_drive_low, 1, "R4 SCL still low while idle");
      pulse(irq_clr);
      chk(irq, 0, "R10 irq cleared by strobe");
      pulse(buf_rd);
      chk(buf_full, 0, "R5 buf_full cleared by read");
      brg_reload = 7'd5;
      recv_byte(8'h3C, 0, 0, hc);
      chk(hc, 6, "R2 high phase with reload 5");
      chk(rx_buf, 8'h3C, "R3 second pattern");
      pulse(buf_rd);
      brg_reload = 7'd3;
   endtask

   task automatic t_ignore;
      int hc;
      recv_byte(8'h81, 1, 0, hc);
      chk(rx_busy, 0, "R1 rx_req during reception ignored");
      chk(rx_buf, 8'h81, "R1 byte intact after ignored request");
      pulse(buf_rd);
   endtask

   task automatic t_overflow;
      int hc;
      recv_byte(8'h5E, 0, 0, hc);
      recv_byte(8'hC3, 0, 0, hc);
      chk(overflow, 1, "R6 overflow set");
      chk(rx_buf, 8'h5E, "R6 buffer keeps old byte");
      chk(buf_full, 1, "R6 buf_full stays set");
      pulse(ov_clr);
      chk(overflow, 0, "R6 overflow cleared by strobe");
      pulse(buf_rd);
   endtask

   task automatic t_wcol;
      int hc;
      recv_byte(8'h69, 2, 0, hc);
      chk(rx_buf, 8'h69, "R7 received byte after collision");
      pulse(wcol_clr);
      chk(wcol, 0, "R7 wcol cleared by strobe");
      pulse(buf_rd);
      buf_wdata = 8'h5A;
      pulse(buf_wr);
      chk(rx_buf, 8'h5A, "R7 idle write loads buffer");
      chk(buf_full, 0, "R7 idle write leaves buf_full");
      chk(wcol, 0, "R7 idle write no collision");
   endtask

   task automatic t_ack(input logic lvl, input bit poke_rx);
      int hc = 0;
      pulse(irq_clr);
      ack_level = lvl;
      pulse(ack_req);
      chk(ack_busy, 1, "R8 ack_busy set");
      chk(sda_drive_low, !lvl, "R8 SDA level during ack");
      chk(scl_drive_low, 1, "R8 SCL low before pulse");
      if (poke_rx) pulse(rx_req);
      while (scl_drive_low) @(negedge clk);
      while (!scl_drive_low) begin hc++; @(negedge clk); end
      chk(hc, 4, "R8 ack pulse high phase");
      chk(ack_busy, 0, "R8 ack_busy cleared");
      chk(irq, 1, "R8 irq after ack");
      chk(sda_drive_low, 0, "R8 SDA released after ack");
      chk(scl_drive_low, 1, "R8 SCL low after ack");
      if (poke_rx) chk(rx_busy, 0, "R1 rx_req during ack ignored");
   endtask

   task automatic t_stretch;
      int hc;
      recv_byte(8'hE7, 0, 3, hc);
      chk(hc, 7, "R11 stretched high phase");
      chk(rx_buf, 8'hE7, "R11 byte intact with stretch");
      pulse(buf_rd);
   endtask

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_basic();
      t_ignore();
      t_overflow();
      t_wcol();
      t_ack(1'b0, 1'b1);
      t_ack(1'b1, 1'b0);
      t_stretch();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule